// File: doc/BRIEF.md
# Magic-Sequence Write Unlock Front End

This block sits between a simple memory-mapped write port and a two-stage watchdog timer core. It guards the core's preload registers and its reload (keep-alive) register. A protected write only takes effect when the two key values have just been written, in order, to the reload offset. Exactly one halfword or word write after the keys consumes the unlock. What that write does depends on its offset and on its access width.

The register window is 16 bytes and little-endian. The write port carries a byte offset, an access width code and a right-justified data value. A byte write uses only bits 7:0 of the data, and a halfword write uses only bits 15:0. The block turns an accepted protected write into a single-cycle strobe towards the core: kick, flag clear, stage-one preload load or stage-two preload load. A registered 20-bit preload value goes with the load strobes. Read decoding and the timer core are built elsewhere.

Top module: `magic_unlock`

## Requirements
- R1: After reset the sequence is locked. All strobes are low, and a protected write issued straight after reset produces no strobe.
- R2: A write of value 0x80 to offset 0xC moves the sequence to the primed state, whatever the current state and whatever the access width (byte, halfword or word). This includes a re-arm from the open state.
- R3: A write of value 0x86 to offset 0xC opens the sequence only while it is primed. In the locked state, a byte write of 0x86 changes nothing.
- R4: A byte write that is not a key value leaves the sequence state unchanged and never produces a strobe.
- R5: In the open state, a halfword write to offset 0xC with bit 8 set raises the kick strobe.
- R6: In the open state, a halfword write to offset 0xC with bit 9 or bit 12 set raises the flag-clear strobe. It does so together with kick when bit 8 is also set.
- R7: In the open state, a word write to offset 0x0 raises the stage-one load strobe and a word write to offset 0x4 raises the stage-two load strobe. In both cases the load value output carries data bits 19:0.
- R8: Any halfword or word write that is not a sequence step returns the sequence to the locked state, whether it acted or not. A second protected write therefore needs a fresh key pair.
- R9: Halfword and word writes at other offsets or widths have no effect apart from relocking. This covers word at 0xC, halfword at 0x0 or 0x4, and any access at 0x8.
- R10: Every strobe is a registered pulse. It is high for exactly the one cycle after the accepting write, and at most one of kick/clear, stage-one load and stage-two load is high in any cycle.
- R11: The reserved width code 2'b11 (codes: 00 byte, 01 halfword, 10 word) is ignored. It neither strobes nor changes the sequence state.
- R12: A key is matched on the whole value of the access at its width. A halfword 0x0186 is not a key, so it relocks. A byte write with data 0xFF80 is the key 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request, one per cycle |
| wr_addr | input | 4 | Byte offset inside the 16-byte window |
| wr_size | input | 2 | Access width: 00 byte, 01 halfword, 10 word, 11 reserved |
| wr_data | input | 32 | Right-justified write value |
| kick_pulse | output | 1 | Restart the stage-one countdown |
| flagclr_pulse | output | 1 | Clear the previous-reboot flag |
| ld1_pulse | output | 1 | Load the stage-one preload |
| ld2_pulse | output | 1 | Load the stage-two preload |
| ld_value | output | 20 | Preload value paired with the load pulses |

## Verification
The hardest situation to reach is the effect of a write on a sequence state that is never visible at the ports. One case is a byte write in the middle of the key pair. Another is a re-arm from the open state, and another is a reserved-width access while open. Each of these is reached by issuing the write and then probing with a known protected halfword kick. Whether that kick fires reveals the hidden state. Relocking and one-shot behaviour are exposed the same way, by a second protected write that must stay silent.

// File: rtl/wu_pkg.sv
package wu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } wu_size_e;

    typedef enum logic [1:0] {
        SEQ_LOCKED = 2'd0,
        SEQ_PRIMED = 2'd1,
        SEQ_OPEN   = 2'd2
    } wu_seq_e;

    // Classification of one write access, produced by the decoder
    typedef struct packed {
        logic key_open;     // value equals the first key at the reload offset
        logic key_confirm;  // value equals the second key at the reload offset
        logic wide;         // valid halfword or word access
        logic kick_req;     // halfword at reload offset with kick bit
        logic clr_req;      // halfword at reload offset with a clear bit
        logic ld1_req;      // word at stage-one preload offset
        logic ld2_req;      // word at stage-two preload offset
    } wu_cls_t;

endpackage

// File: rtl/wu_decode.sv
module wu_decode
    import wu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int KEY_W  = 8,
    parameter logic [KEY_W-1:0]  KEY_OPEN    = 8'h80,
    parameter logic [KEY_W-1:0]  KEY_CONFIRM = 8'h86,
    parameter logic [ADDR_W-1:0] RELOAD_OFS  = 4'hC,
    parameter logic [ADDR_W-1:0] PRE1_OFS    = 4'h0,
    parameter logic [ADDR_W-1:0] PRE2_OFS    = 4'h4,
    parameter int KICK_BIT  = 8,
    parameter int CLR_BIT_A = 9,
    parameter int CLR_BIT_B = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output wu_cls_t           cls
);
    localparam int HALF_W = 2 * KEY_W;

    wu_size_e          size;
    logic [DATA_W-1:0] acc_val;
    logic              valid;
    logic              at_reload;

    always_comb begin
        size = wu_size_e'(wr_size);
        unique case (size)
            SZ_BYTE: acc_val = DATA_W'(wr_data[KEY_W-1:0]);
            SZ_HALF: acc_val = DATA_W'(wr_data[HALF_W-1:0]);
            SZ_WORD: acc_val = wr_data;
            default: acc_val = '0;
        endcase
        valid     = wr_en && (size != SZ_RSVD);
        at_reload = (wr_addr == RELOAD_OFS);

        cls.key_open    = valid && at_reload && (acc_val == DATA_W'(KEY_OPEN));
        cls.key_confirm = valid && at_reload && (acc_val == DATA_W'(KEY_CONFIRM));
        cls.wide        = valid && (size != SZ_BYTE);
        cls.kick_req    = (size == SZ_HALF) && at_reload && acc_val[KICK_BIT];
        cls.clr_req     = (size == SZ_HALF) && at_reload &&
                          (acc_val[CLR_BIT_A] || acc_val[CLR_BIT_B]);
        cls.ld1_req     = (size == SZ_WORD) && (wr_addr == PRE1_OFS);
        cls.ld2_req     = (size == SZ_WORD) && (wr_addr == PRE2_OFS);
    end

endmodule

// File: rtl/wu_seq.sv
module wu_seq
    import wu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wu_cls_t cls,
    output logic    grant,
    output wu_seq_e state
);
    typedef struct packed {
        wu_seq_e st;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        grant = 1'b0;
        if (cls.key_open) begin
            seq_d.st = SEQ_PRIMED;
        end else if (cls.key_confirm && (seq_q.st == SEQ_PRIMED)) begin
            seq_d.st = SEQ_OPEN;
        end else if (cls.wide) begin
            // one non-sequence wide write consumes whatever unlock exists
            grant    = (seq_q.st == SEQ_OPEN);
            seq_d.st = SEQ_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: SEQ_LOCKED};
        else        seq_q <= seq_d;
    end

    assign state = seq_q.st;

endmodule

// File: rtl/wu_strobe.sv
module wu_strobe
    import wu_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wu_cls_t          cls,
    input  logic             grant,
    input  logic [PRE_W-1:0] wr_val,
    output logic             kick_pulse,
    output logic             flagclr_pulse,
    output logic             ld1_pulse,
    output logic             ld2_pulse,
    output logic [PRE_W-1:0] ld_value
);
    typedef struct packed {
        logic             kick;
        logic             clr;
        logic             ld1;
        logic             ld2;
        logic [PRE_W-1:0] val;
    } strobe_reg_t;

    strobe_reg_t stb_d, stb_q;

    always_comb begin
        stb_d      = stb_q;
        stb_d.kick = grant && cls.kick_req;
        stb_d.clr  = grant && cls.clr_req;
        stb_d.ld1  = grant && cls.ld1_req;
        stb_d.ld2  = grant && cls.ld2_req;
        if (grant && (cls.ld1_req || cls.ld2_req)) begin
            stb_d.val = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= stb_d;
    end

    assign kick_pulse    = stb_q.kick;
    assign flagclr_pulse = stb_q.clr;
    assign ld1_pulse     = stb_q.ld1;
    assign ld2_pulse     = stb_q.ld2;
    assign ld_value      = stb_q.val;

endmodule

// File: rtl/magic_unlock.sv
module magic_unlock
    import wu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 20,
    parameter int KEY_W  = 8,
    parameter logic [KEY_W-1:0]  KEY_OPEN    = 8'h80,
    parameter logic [KEY_W-1:0]  KEY_CONFIRM = 8'h86,
    parameter logic [ADDR_W-1:0] RELOAD_OFS  = 4'hC,
    parameter logic [ADDR_W-1:0] PRE1_OFS    = 4'h0,
    parameter logic [ADDR_W-1:0] PRE2_OFS    = 4'h4,
    parameter int KICK_BIT  = 8,
    parameter int CLR_BIT_A = 9,
    parameter int CLR_BIT_B = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              kick_pulse,
    output logic              flagclr_pulse,
    output logic              ld1_pulse,
    output logic              ld2_pulse,
    output logic [PRE_W-1:0]  ld_value
);
    wu_cls_t cls;
    logic    grant;
    wu_seq_e seq_state;

    wu_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
        .KEY_OPEN(KEY_OPEN), .KEY_CONFIRM(KEY_CONFIRM),
        .RELOAD_OFS(RELOAD_OFS), .PRE1_OFS(PRE1_OFS), .PRE2_OFS(PRE2_OFS),
        .KICK_BIT(KICK_BIT), .CLR_BIT_A(CLR_BIT_A), .CLR_BIT_B(CLR_BIT_B)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_size(wr_size),
        .wr_data(wr_data),
        .cls    (cls)
    );

    wu_seq u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .cls  (cls),
        .grant(grant),
        .state(seq_state)
    );

    wu_strobe #(.PRE_W(PRE_W)) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .cls          (cls),
        .grant        (grant),
        .wr_val       (wr_data[PRE_W-1:0]),
        .kick_pulse   (kick_pulse),
        .flagclr_pulse(flagclr_pulse),
        .ld1_pulse    (ld1_pulse),
        .ld2_pulse    (ld2_pulse),
        .ld_value     (ld_value)
    );

endmodule

// File: rtl/wu_unlock_chk.sv
module wu_unlock_chk
    import wu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int PRE_W  = 20,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 4'hC,
    parameter logic [ADDR_W-1:0] PRE1_OFS   = 4'h0,
    parameter logic [ADDR_W-1:0] PRE2_OFS   = 4'h4,
    parameter int KICK_BIT  = 8,
    parameter int CLR_BIT_A = 9,
    parameter int CLR_BIT_B = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_size,
    input logic [PRE_W-1:0]  wr_low,
    input logic              kick_pulse,
    input logic              flagclr_pulse,
    input logic              ld1_pulse,
    input logic              ld2_pulse,
    input logic [PRE_W-1:0]  ld_value,
    input wu_seq_e           seq_state
);
    logic any_stb;
    assign any_stb = kick_pulse || flagclr_pulse || ld1_pulse || ld2_pulse;

    // R5: a kick follows a halfword at the reload offset with the kick bit
    p_kick_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_pulse |-> $past(wr_en && wr_size == 2'd1 && wr_addr == RELOAD_OFS && wr_low[KICK_BIT]));

    // R6: a clear follows a halfword at the reload offset with a clear bit
    p_clr_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flagclr_pulse |-> $past(wr_en && wr_size == 2'd1 && wr_addr == RELOAD_OFS &&
                                (wr_low[CLR_BIT_A] || wr_low[CLR_BIT_B])));

    // R7: stage-one load follows a word at its offset and carries that value
    p_ld1_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld1_pulse |-> ($past(wr_en && wr_size == 2'd2 && wr_addr == PRE1_OFS) &&
                       ld_value == $past(wr_low)));

    // R7: stage-two load follows a word at its offset and carries that value
    p_ld2_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld2_pulse |-> ($past(wr_en && wr_size == 2'd2 && wr_addr == PRE2_OFS) &&
                       ld_value == $past(wr_low)));

    // R4: byte writes never strobe
    p_byte_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd0) |=> !any_stb);

    // R11: reserved-width writes never strobe
    p_rsvd_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd3) |=> !any_stb);

    // R10: strobes last one cycle and need a write in the cycle before
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !any_stb);

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld1_pulse, ld2_pulse, kick_pulse || flagclr_pulse}));

    // R8: any strobe means the sequence has just relocked
    p_relock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> seq_state == SEQ_LOCKED);

    // R2: the sequence state never takes the unused encoding
    p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state != wu_seq_e'(2'd3));

endmodule

bind magic_unlock wu_unlock_chk #(
    .ADDR_W(ADDR_W), .PRE_W(PRE_W),
    .RELOAD_OFS(RELOAD_OFS), .PRE1_OFS(PRE1_OFS), .PRE2_OFS(PRE2_OFS),
    .KICK_BIT(KICK_BIT), .CLR_BIT_A(CLR_BIT_A), .CLR_BIT_B(CLR_BIT_B)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_size      (wr_size),
    .wr_low       (wr_data[PRE_W-1:0]),
    .kick_pulse   (kick_pulse),
    .flagclr_pulse(flagclr_pulse),
    .ld1_pulse    (ld1_pulse),
    .ld2_pulse    (ld2_pulse),
    .ld_value     (ld_value),
    .seq_state    (seq_state)
);

// File: tb/sim_magic_unlock.sv
`timescale 1ns/1ps
module sim_magic_unlock;
    localparam logic [1:0] SB = 2'd0, SH = 2'd1, SW = 2'd2, SR = 2'd3;
    localparam logic [3:0] REL = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        kick_pulse, flagclr_pulse, ld1_pulse, ld2_pulse;
    logic [19:0] ld_value;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic o_kick, o_clr, o_ld1, o_ld2;
    logic [19:0] o_val;

    always #2.5 clk = ~clk;

    magic_unlock u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .kick_pulse(kick_pulse),
        .flagclr_pulse(flagclr_pulse), .ld1_pulse(ld1_pulse),
        .ld2_pulse(ld2_pulse), .ld_value(ld_value)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one write; outputs captured at the negedge after the accepting edge
    task automatic put(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        o_kick = kick_pulse; o_clr = flagclr_pulse;
        o_ld1 = ld1_pulse; o_ld2 = ld2_pulse; o_val = ld_value;
    endtask

    task automatic expect_stb(input string tag, input logic k, input logic c,
                              input logic l1, input logic l2);
        chk({tag, " kick"}, 32'(o_kick), 32'(k));
        chk({tag, " clr"},  32'(o_clr),  32'(c));
        chk({tag, " ld1"},  32'(o_ld1),  32'(l1));
        chk({tag, " ld2"},  32'(o_ld2),  32'(l2));
    endtask

    task automatic unlock();
        put(REL, SB, 32'h80);
        put(REL, SB, 32'h86);
    endtask

    // probe: a protected kick tells whether the sequence was open
    task automatic probe(input string tag, input logic exp_open);
        put(REL, SH, 32'h0100);
        expect_stb(tag, exp_open, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset kick", 32'(kick_pulse), 0);
        chk("R1 reset ld1", 32'(ld1_pulse), 0);
        chk("R1 reset value", 32'(ld_value), 0);
        probe("R1 locked after reset", 1'b0);
    endtask

    task automatic t_kick();
        unlock();
        probe("R5 kick", 1'b1);
        @(negedge clk);
        chk("R10 kick one cycle", 32'(kick_pulse), 0);
    endtask

    task automatic t_clear();
        unlock(); put(REL, SH, 32'h0200);
        expect_stb("R6 bit9 clear", 1'b0, 1'b1, 1'b0, 1'b0);
        unlock(); put(REL, SH, 32'h1000);
        expect_stb("R6 bit12 clear", 1'b0, 1'b1, 1'b0, 1'b0);
        unlock(); put(REL, SH, 32'h1300);
        expect_stb("R6 kick and clear", 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R10 clear one cycle", 32'(flagclr_pulse), 0);
    endtask

    task automatic t_preload();
        unlock(); put(4'h0, SW, 32'hABCDE123);
        expect_stb("R7 stage1 load", 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7 stage1 value", 32'(o_val), 32'h0DE123);
        unlock(); put(4'h4, SW, 32'hFFF54321);
        expect_stb("R7 stage2 load", 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 stage2 value", 32'(o_val), 32'h054321);
        @(negedge clk);
        chk("R10 load one cycle", 32'(ld2_pulse), 0);
        chk("R10 value held", 32'(ld_value), 32'h054321);
    endtask

    task automatic t_oneshot();
        unlock();
        probe("R8 first kick", 1'b1);
        probe("R8 second kick needs new keys", 1'b0);
        unlock(); put(4'h8, SH, 32'h0100);
        expect_stb("R9 offset 8 inert", 1'b0, 1'b0, 1'b0, 1'b0);
        probe("R8 relocked by offset 8", 1'b0);
    endtask

    task automatic t_other();
        unlock(); put(REL, SW, 32'h0000_1300);
        expect_stb("R9 word at reload inert", 1'b0, 1'b0, 1'b0, 1'b0);
        probe("R8 relocked by word at reload", 1'b0);
        unlock(); put(4'h0, SH, 32'h0000_0123);
        expect_stb("R9 half at 0 inert", 1'b0, 1'b0, 1'b0, 1'b0);
        unlock(); put(4'h4, SH, 32'h0000_0456);
        expect_stb("R9 half at 4 inert", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 value unchanged", 32'(o_val), 32'h054321);
    endtask

    task automatic t_bytes();
        put(REL, SB, 32'h80);
        put(REL, SB, 32'h55);
        put(4'h0, SB, 32'h12);
        chk("R4 byte no strobe", 32'(o_ld1), 0);
        put(REL, SB, 32'h86);
        probe("R4 bytes between keys ignored", 1'b1);
        unlock();
        put(REL, SB, 32'h00);
        put(4'h4, SB, 32'h01);
        expect_stb("R4 byte while open", 1'b0, 1'b0, 1'b0, 1'b0);
        probe("R4 still open after bytes", 1'b1);
    endtask

    task automatic t_rearm();
        put(REL, SB, 32'h80); put(REL, SH, 32'h0080); put(REL, SH, 32'h0086);
        probe("R2 halfword keys", 1'b1);
        put(REL, SW, 32'h80); put(REL, SW, 32'h86);
        probe("R2 word keys", 1'b1);
        unlock(); put(REL, SB, 32'h80);
        probe("R2 re-arm from open", 1'b0);
        put(REL, SB, 32'h80); put(REL, SB, 32'h80); put(REL, SB, 32'h86);
        probe("R2 repeated first key", 1'b1);
    endtask

    task automatic t_order();
        put(REL, SB, 32'h86); put(REL, SB, 32'h80);
        probe("R3 reversed keys", 1'b0);
        put(REL, SB, 32'h86);
        probe("R3 second key alone", 1'b0);
    endtask

    task automatic t_fullval();
        put(REL, SB, 32'h80); put(REL, SH, 32'h0186);
        probe("R12 0x0186 not a key", 1'b0);
        put(REL, SB, 32'hFF80); put(REL, SB, 32'hA586);
        probe("R12 byte keys use low byte", 1'b1);
    endtask

    task automatic t_rsvd();
        unlock(); put(REL, SR, 32'h0100);
        expect_stb("R11 reserved no strobe", 1'b0, 1'b0, 1'b0, 1'b0);
        probe("R11 reserved keeps open", 1'b1);
        put(REL, SB, 32'h80); put(REL, SR, 32'h86);
        put(REL, SB, 32'h86);
        probe("R11 reserved keeps primed", 1'b1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            vectors++; miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_kick();
        t_clear();
        t_preload();
        t_oneshot();
        t_other();
        t_bytes();
        t_rearm();
        t_order();
        t_fullval();
        t_rsvd();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule